// File: doc/BRIEF.md
# Slave Serial Audio Transmitter

This block sends a stereo pair of 16-bit samples on a three-wire serial audio link as a slave. The bit clock and the frame clock come from an external master. The block watches both clocks in its own system-clock domain and sends one channel word per half-frame on a single data pin, most significant bit first. A static format input chooses left-justified or I2S framing. The core supplies left and right samples with a one-cycle valid strobe. The block holds the latest strobed pair and takes a snapshot of it when a left half-frame starts. A mute input zeroes the transmitted bits.

The sequencer has four states, and these are its transitions:
- `ST_IDLE` is the state after reset. Bit-clock falls keep the block in `ST_IDLE`.
- Any frame-clock edge goes to `ST_SHIFT` in left-justified mode, or to `ST_LEAD` in I2S mode.
- `ST_LEAD` drives a zero for one bit slot. The next bit-clock fall goes to `ST_SHIFT`.
- `ST_SHIFT` sends one bit per bit-clock fall. The fall that follows the sixteenth bit goes to `ST_PAD`.
- `ST_PAD` holds the pin low until the next frame-clock edge. That edge restarts the sequence.

A frame-clock edge takes priority over a bit-clock fall in every state.

Top module: `slave_audio_tx`

## Requirements
- R1: While reset is held, and after reset until the first frame-clock transition, `sdata_o` is 0, even if the bit clock toggles.
- R2: Each channel word is 16 bits, sent most significant bit first. One bit is sent per bit slot, and a bit slot runs from one bit-clock falling edge to the next.
- R3: Left-justified mode (`fmt_i2s`=0). Bit 15 of the word is driven in the system-clock cycle after the frame-clock transition, so it fills the first bit slot of the half-frame. Bit 15-k fills slot k.
- R4: I2S mode (`fmt_i2s`=1). The first bit slot after a frame-clock transition carries 0. Bit 15 follows one bit clock later, so bit 16-k fills slot k for k from 1 to 16.
- R5: Channel mapping. In left-justified mode, frame clock high is the left channel. In I2S mode, frame clock low is the left channel.
- R6: `sdata_o` changes only in the cycle after a detected bit-clock falling edge or a detected frame-clock transition. Otherwise it holds its value.
- R7: After the sixteenth bit, `sdata_o` is 0 for every remaining bit slot of that half-frame.
- R8: The left half-frame sends the most recently strobed left sample. The right half-frame that follows sends the right sample strobed together with that left sample, even if a new pair is strobed during the left half-frame.
- R9: Every bit launched while `mute_i` is 1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. It samples the link clocks. |
| rst_n | input | 1 | Active-low synchronous reset. |
| bclk_i | input | 1 | Bit clock from the external master. |
| fsync_i | input | 1 | Frame (word select) clock from the external master. |
| fmt_i2s | input | 1 | Framing select: 0 is left-justified, 1 is I2S. |
| mute_i | input | 1 | Forces transmitted bits to zero while it is 1. |
| smp_valid | input | 1 | One-cycle strobe that accepts `smp_left` and `smp_right`. |
| smp_left | input | 16 | Left-channel sample. |
| smp_right | input | 16 | Right-channel sample. |
| sdata_o | output | 1 | Serial data output. |

## Verification
On every cycle, the assertions check the following:
- the data pin moves only after a bit-clock fall or a frame-clock transition;
- the pin stays low in the idle, lead and pad states;
- muted launches give zero;
- the bit counter never passes the word length.

Only the bench scenarios can show the following:
- bit order and slot alignment in both framings;
- the channel-to-level mapping;
- the snapshot that keeps a pair together while a new pair arrives mid-frame.

These are checked by comparing every bit slot against words the bench predicts.

// File: rtl/sat_pkg.sv
package sat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_PAD
    } tx_state_e;
endpackage

// File: rtl/sat_edge_det.sv
module sat_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fsync_i,
    output logic bclk_fall,
    output logic frame_edge
);
    logic bclk_q;
    logic fsync_q;
    logic primed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            fsync_q <= 1'b0;
            primed  <= 1'b0;
        end else begin
            bclk_q  <= bclk_i;
            fsync_q <= fsync_i;
            primed  <= 1'b1;
        end
    end

    // No edge is reported until the stored levels hold real samples.
    assign bclk_fall  = primed & bclk_q & ~bclk_i;
    assign frame_edge = primed & (fsync_q ^ fsync_i);
endmodule

// File: rtl/sat_pair_latch.sv
module sat_pair_latch #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_left,
    input  logic [DW-1:0] smp_right,
    input  logic          take_pair,
    input  logic          sel_left,
    output logic [DW-1:0] word_o
);
    logic [DW-1:0] hold_l;
    logic [DW-1:0] hold_r;
    logic [DW-1:0] live_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (smp_valid) begin
            hold_l <= smp_left;
            hold_r <= smp_right;
        end
    end

    // The right word is frozen when the left half-frame starts (R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_r <= '0;
        end else if (take_pair) begin
            live_r <= hold_r;
        end
    end

    assign word_o = sel_left ? hold_l : live_r;
endmodule

// File: rtl/sat_tx_fsm.sv
module sat_tx_fsm
    import sat_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_fall,
    input  logic          frame_edge,
    input  logic          fsync_i,
    input  logic          fmt_i2s,
    input  logic          mute_i,
    input  logic [DW-1:0] word_i,
    output logic          is_left,
    output logic          left_start,
    output logic          sdata_o
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW);

    tx_state_e     st;
    tx_state_e     nxt;
    logic [DW-1:0] shreg;
    logic [CW-1:0] sent;
    logic          sdata_q;

    assign is_left    = fmt_i2s ? ~fsync_i : fsync_i;
    assign left_start = frame_edge & is_left;

    always_comb begin
        nxt = st;
        if (frame_edge) begin
            nxt = fmt_i2s ? ST_LEAD : ST_SHIFT;
        end else if (bclk_fall) begin
            unique case (st)
                ST_IDLE:  nxt = ST_IDLE;
                ST_LEAD:  nxt = ST_SHIFT;
                ST_SHIFT: nxt = (sent == LAST) ? ST_PAD : ST_SHIFT;
                ST_PAD:   nxt = ST_PAD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            sent    <= '0;
            sdata_q <= 1'b0;
        end else if (frame_edge) begin
            if (fmt_i2s) begin
                shreg   <= word_i;
                sent    <= '0;
                sdata_q <= 1'b0;
            end else begin
                shreg   <= word_i << 1;
                sent    <= CW'(1);
                sdata_q <= word_i[DW-1] & ~mute_i;
            end
        end else if (bclk_fall) begin
            unique case (st)
                ST_LEAD, ST_SHIFT: begin
                    if (st == ST_SHIFT && sent == LAST) begin
                        sdata_q <= 1'b0;
                    end else begin
                        sdata_q <= shreg[DW-1] & ~mute_i;
                        shreg   <= shreg << 1;
                        sent    <= sent + 1'b1;
                    end
                end
                ST_IDLE, ST_PAD: sdata_q <= 1'b0;
            endcase
        end
    end

    assign sdata_o = sdata_q;

    assert_quiet_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_fall || frame_edge) |=> $stable(sdata_q));
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sdata_q);
    assert_lead_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LEAD) |-> !sdata_q);
    assert_pad_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAD) |-> !sdata_q);
    assert_mute_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_i && (bclk_fall || frame_edge)) |=> !sdata_q);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sent <= LAST);
endmodule

// File: rtl/slave_audio_tx.sv
module slave_audio_tx #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_i,
    input  logic          fsync_i,
    input  logic          fmt_i2s,
    input  logic          mute_i,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_left,
    input  logic [DW-1:0] smp_right,
    output logic          sdata_o
);
    logic          bclk_fall;
    logic          frame_edge;
    logic          is_left;
    logic          left_start;
    logic [DW-1:0] word;

    sat_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk_i),
        .fsync_i   (fsync_i),
        .bclk_fall (bclk_fall),
        .frame_edge(frame_edge)
    );

    sat_pair_latch #(.DW(DW)) u_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_left (smp_left),
        .smp_right(smp_right),
        .take_pair(left_start),
        .sel_left (is_left),
        .word_o   (word)
    );

    sat_tx_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_fall (bclk_fall),
        .frame_edge(frame_edge),
        .fsync_i   (fsync_i),
        .fmt_i2s   (fmt_i2s),
        .mute_i    (mute_i),
        .word_i    (word),
        .is_left   (is_left),
        .left_start(left_start),
        .sdata_o   (sdata_o)
    );
endmodule

// File: tb/slave_audio_tx_tb_top.sv
module slave_audio_tx_tb_top;
    localparam int SLOTS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b1;
    logic        fsync = 1'b0;
    logic        fmt = 1'b0;
    logic        mute = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_left = '0;
    logic [15:0] smp_right = '0;
    logic        sdata;

    int n_cmp = 0;
    int n_bad = 0;

    logic  exp_q[$];
    string tag_q[$];
    event  smp_ev;

    always #2 clk = ~clk;

    slave_audio_tx dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_i   (bclk),
        .fsync_i  (fsync),
        .fmt_i2s  (fmt),
        .mute_i   (mute),
        .smp_valid(smp_valid),
        .smp_left (smp_left),
        .smp_right(smp_right),
        .sdata_o  (sdata)
    );

    // Monitor: takes the oldest prediction and compares it with the pin.
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() > 0) begin
                automatic logic  e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                n_cmp++;
                if (sdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: sdata=%b expected=%b at %0t", t, sdata, e, $time);
                end
            end
        end
    end

    task automatic strobe_pair(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        smp_left = l;
        smp_right = r;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Drives one half-frame of SLOTS bit slots and predicts each slot.
    // The frame clock moves at the first bit-clock fall.
    task automatic half_frame(input logic lvl, input logic [15:0] w, input string tag,
                              input int strobe_slot, input logic [15:0] nl,
                              input logic [15:0] nr);
        for (int s = 0; s < SLOTS; s++) begin
            logic e;
            @(negedge clk);
            bclk = 1'b0;
            if (s == 0) fsync = lvl;
            repeat (4) @(negedge clk);
            bclk = 1'b1;
            if (s == strobe_slot) begin
                smp_left = nl;
                smp_right = nr;
                smp_valid = 1'b1;
                @(negedge clk);
                smp_valid = 1'b0;
                repeat (2) @(negedge clk);
            end else begin
                repeat (3) @(negedge clk);
            end
            if (fmt) e = (s >= 1 && s <= 16) ? w[16 - s] : 1'b0;
            else     e = (s < 16) ? w[15 - s] : 1'b0;
            exp_q.push_back(e);
            tag_q.push_back(s >= 16 ? "R7" : tag);
            -> smp_ev;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        n_cmp++;
        if (sdata !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: sdata=%b expected=0 in reset", sdata);
        end
        rst_n = 1'b1;

        // R1: the bit clock runs but the frame clock holds, so the pin stays idle.
        half_frame(1'b0, 16'h0000, "R1", -1, '0, '0);

        // Left-justified framing.
        strobe_pair(16'hA5C3, 16'h3C5A);
        half_frame(1'b1, 16'hA5C3, "R3", -1, '0, '0);
        half_frame(1'b0, 16'h3C5A, "R5", -1, '0, '0);

        // R8: a new pair arrives mid-left and must not reach this frame's right word.
        strobe_pair(16'h1234, 16'hFEDC);
        half_frame(1'b1, 16'h1234, "R2", 8, 16'h0F0F, 16'hF00F);
        half_frame(1'b0, 16'hFEDC, "R8", -1, '0, '0);
        half_frame(1'b1, 16'h0F0F, "R8", -1, '0, '0);
        half_frame(1'b0, 16'hF00F, "R2", -1, '0, '0);

        // R9: mute covers a whole frame.
        strobe_pair(16'hFFFF, 16'hFFFF);
        mute = 1'b1;
        half_frame(1'b1, 16'h0000, "R9", -1, '0, '0);
        half_frame(1'b0, 16'h0000, "R9", -1, '0, '0);
        mute = 1'b0;

        // I2S framing: frame clock high is right, low is left.
        strobe_pair(16'h8001, 16'h7FFE);
        fmt = 1'b1;
        half_frame(1'b1, 16'hFFFF, "R4", -1, '0, '0);
        half_frame(1'b0, 16'h8001, "R4", -1, '0, '0);
        half_frame(1'b1, 16'h7FFE, "R5", -1, '0, '0);
        strobe_pair(16'hC001, 16'h5AA5);
        half_frame(1'b0, 16'hC001, "R5", -1, '0, '0);
        half_frame(1'b1, 16'h5AA5, "R2", -1, '0, '0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule